// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash transaction at a time on a single-lane SPI bus in mode 0. Software writes a packed command word, and an address when the command asks for one. The sequencer then drives one of its chip selects low and sends phases in this order: the opcode, an optional address, and optional dummy clocks. It then either streams bytes from a transmit FIFO to the flash or collects bytes from the flash into a receive FIFO. Every phase is sent most significant bit first. SCLK is the system clock divided by the even parameter `SCLK_DIV`.

A plain register port (select, write strobe, read strobe, 32-bit data) stands in for the host bus. The registers are:

| Select | Register | Access |
|---|---|---|
| 0 | command word | write |
| 1 | address | write |
| 2 | custom address width | read/write |
| 3 | data port | write pushes to TX, read pops from RX |
| 4 | status | read |
| 5 | FIFO status | read |
| 6 | soft reset | read/write |

Software polls the status register until it reads idle, and keeps the FIFOs served through the data port. A soft reset returns the sequencer and both FIFOs to their initial state.

The state machine has these states:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a command word |
| ST_ARMED | Command accepted, waiting for the address write |
| ST_OPC | Sending the opcode |
| ST_ADR | Sending the address |
| ST_DUMMY | Sending dummy clocks |
| ST_DATA | Transferring the data bytes |
| ST_TAIL | Holding chip select for one SCLK period after the last bit |

It takes these transitions:

- ST_IDLE goes to ST_ARMED when a command word with a nonzero address mode is written.
- ST_IDLE goes to ST_OPC when a command word with address mode 0 is written.
- ST_ARMED goes to ST_OPC when the address is written.
- At the end of each bit phase, the sequencer goes to the next phase the command enables: ST_ADR, ST_DUMMY, ST_DATA or ST_TAIL.
- ST_TAIL goes to ST_IDLE after `SCLK_DIV` system cycles.
- A soft reset sends any state to ST_IDLE.

Top module: `flash_cmd_engine`

## Requirements
- R1: The command word has these fields: opcode in bits 7:0, dummy clock count in 11:8, direction in bit 12 (1 = to the flash), address mode in 15:14, byte count in 29:16 and chip-select index in 31:30. The opcode is sent first, MSB first, with only the selected `spi_cs_n` bit low. MOSI is stable at each rising SCLK edge.
- R2: Address mode 1 sends 24 address bits and mode 2 sends 32. Mode 3 sends (custom width register + 1) bits. In every mode the address is the low bits of the address register, sent MSB first.
- R3: A command word with address mode 0 starts the transaction at once. With a nonzero address mode, the sequencer reports busy but leaves all chip selects high until the address register is written.
- R4: A nonzero dummy count inserts that many SCLK cycles with MOSI low between the address and data phases.
- R5: Outbound data is sent from each TX word starting with byte lane 0 (bits 7:0), MSB first in each byte. Unused lanes of a trailing partial word are not sent.
- R6: Inbound bytes fill each RX word starting with lane 0. A trailing partial word has its unused upper lanes set to zero.
- R7: Status bit 0 reads 1 from the accepted command write until chip select is released, and 0 otherwise.
- R8: The FIFO status register has TX full in bit 0, TX empty in bit 1, RX empty in bit 2, RX full in bit 3, TX free entries in 12:8 and RX entries in 20:16. After reset it reads 0x1006 with depth 16.
- R9: Writing 1 to bit 0 of the soft-reset register aborts any transaction, releases chip select and empties both FIFOs. The bit reads 1 in the cycle after the write and 0 afterwards.
- R10: A transaction with a byte count of 0 has no data phase. It neither pops the TX FIFO nor pushes the RX FIFO, whatever the direction bit says.
- R11: Command and address writes while busy are ignored, apart from the one address write that ST_ARMED waits for.
- R12: Chip select rises exactly one SCLK period (`SCLK_DIV` system clocks) after the last falling SCLK edge. At most one chip select is low at a time, and SCLK stays low while all chip selects are high.
- R13: An inbound transfer pauses SCLK with chip select held low while the RX FIFO is full, and loses no byte. An outbound transfer pauses in the same way while the TX FIFO is empty and bytes remain to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on the data port) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses a flash model that records MOSI at each rising SCLK edge and drives a position-dependent byte pattern on MISO. It checks the bit counts of every address width, dummy phase and partial word. A design with the wrong lane order or a misplaced shift would garble a byte or fill the unused lanes of a partial word with stale bits. An address-only command is issued with a TX word already queued, so a design that entered a data phase would consume that word. Both FIFO stalls are forced. A design without the stalls would overrun the RX FIFO or send garbage past the last TX word, and a wrong stall would leave chip select released or the byte count off. The bench also checks that writes issued mid-transaction are ignored, that the chip-select tail lasts exactly `SCLK_DIV` cycles, and that a soft reset issued during a stalled transfer empties both FIFOs.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_OPC, ST_ADR, ST_DUMMY, ST_DATA, ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [1:0]  cs;
        logic [13:0] nbytes;
        logic [1:0]  amode;
        logic        rsvd;
        logic        dir_out;
        logic [3:0]  dummy;
        logic [7:0]  opcode;
    } cmd_word_t;

    localparam logic [2:0] SEL_CMD   = 3'd0;
    localparam logic [2:0] SEL_ADDR  = 3'd1;
    localparam logic [2:0] SEL_ABITS = 3'd2;
    localparam logic [2:0] SEL_DATA  = 3'd3;
    localparam logic [2:0] SEL_STAT  = 3'd4;
    localparam logic [2:0] SEL_FIFO  = 3'd5;
    localparam logic [2:0] SEL_SRST  = 3'd6;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/flash_seq_fifo.sv
`timescale 1ns/1ps
module flash_seq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (level != FULL);
    assign do_pop  = pop && (level != '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_core.sv
`timescale 1ns/1ps
module flash_seq_core
    import flash_seq_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int NUM_CS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cmd_we,
    input  logic              addr_we,
    input  logic [31:0]       wdata,
    input  logic [4:0]        abits,
    input  logic              tx_empty,
    input  logic [31:0]       tx_word,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [31:0]       rx_word,
    output logic              busy,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int DW  = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int BLW = 17;
    localparam logic [DW-1:0] LAST  = DW'(SCLK_DIV - 1);
    localparam logic [DW-1:0] HALFV = DW'(SCLK_DIV / 2);

    seq_state_e state, state_nx;
    cmd_word_t  cmd_q, wcmd, lcmd;
    logic [31:0]    addr_q, sh, rx_sh, rx_cur, rx_aligned;
    logic [DW-1:0]  div_cnt;
    logic [BLW-1:0] bits_left;
    logic [4:0]     wbits;
    logic [5:0]     adr_bits;
    logic bit_phase, in_slot, slot_first, slot_last, rise_now;
    logic bit_end, phase_end, word_start, stall;
    logic has_adr, has_dum, has_dat;

    assign wcmd = cmd_word_t'(wdata);
    assign lcmd = (state == ST_IDLE) ? wcmd : cmd_q;

    assign has_adr = (cmd_q.amode != 2'd0);
    assign has_dum = (cmd_q.dummy != 4'd0);
    assign has_dat = (cmd_q.nbytes != 14'd0);

    always_comb begin
        unique case (cmd_q.amode)
            2'd1:    adr_bits = 6'd24;
            2'd2:    adr_bits = 6'd32;
            2'd3:    adr_bits = {1'b0, abits} + 6'd1;
            default: adr_bits = 6'd0;
        endcase
    end

    assign bit_phase  = (state == ST_OPC) || (state == ST_ADR) ||
                        (state == ST_DUMMY) || (state == ST_DATA);
    assign in_slot    = bit_phase || (state == ST_TAIL);
    assign slot_first = (div_cnt == '0);
    assign slot_last  = (div_cnt == LAST);
    assign rise_now   = bit_phase && (div_cnt == HALFV);
    assign word_start = (state == ST_DATA) && (wbits == 5'd0) && slot_first;
    assign stall      = word_start && (cmd_q.dir_out ? tx_empty : rx_full);
    assign bit_end    = bit_phase && slot_last && !stall;
    assign phase_end  = bit_end && (bits_left == BLW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_we)  state_nx = (wcmd.amode != 2'd0) ? ST_ARMED : ST_OPC;
            ST_ARMED: if (addr_we) state_nx = ST_OPC;
            ST_OPC:   if (phase_end)
                          state_nx = has_adr ? ST_ADR : has_dum ? ST_DUMMY :
                                     has_dat ? ST_DATA : ST_TAIL;
            ST_ADR:   if (phase_end)
                          state_nx = has_dum ? ST_DUMMY : has_dat ? ST_DATA : ST_TAIL;
            ST_DUMMY: if (phase_end) state_nx = has_dat ? ST_DATA : ST_TAIL;
            ST_DATA:  if (phase_end) state_nx = ST_TAIL;
            ST_TAIL:  if (slot_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            cmd_q     <= '0;
            addr_q    <= '0;
            div_cnt   <= '0;
            bits_left <= '0;
            wbits     <= '0;
            sh        <= '0;
            rx_sh     <= '0;
        end else begin
            if (state == ST_IDLE && cmd_we)   cmd_q  <= wcmd;
            if (state == ST_ARMED && addr_we) addr_q <= wdata;

            if (!in_slot || slot_last) div_cnt <= '0;
            else if (!stall)           div_cnt <= div_cnt + 1'b1;

            if (state_nx != state) begin
                unique case (state_nx)
                    ST_OPC: begin
                        bits_left <= BLW'(8);
                        sh        <= {lcmd.opcode, 24'd0};
                    end
                    ST_ADR: begin
                        bits_left <= BLW'(adr_bits);
                        sh        <= addr_q << (6'd32 - adr_bits);
                    end
                    ST_DUMMY: begin
                        bits_left <= BLW'(cmd_q.dummy);
                        sh        <= '0;
                    end
                    ST_DATA: begin
                        bits_left <= {cmd_q.nbytes, 3'b000};
                        wbits     <= '0;
                        sh        <= '0;
                    end
                    default: sh <= '0;
                endcase
            end else if (bit_end) begin
                sh        <= sh << 1;
                bits_left <= bits_left - 1'b1;
                if (state == ST_DATA) wbits <= wbits + 1'b1;
            end else if (tx_pop) begin
                sh <= swap_bytes(tx_word);
            end

            if (rise_now && state == ST_DATA && !cmd_q.dir_out)
                rx_sh <= rx_cur;
        end
    end

    // receive word assembly: first byte lands in lane 0
    assign rx_cur     = (rise_now) ? {rx_sh[30:0], miso} : rx_sh;
    assign rx_aligned = rx_cur << {2'd3 - wbits[4:3], 3'b000};
    assign rx_word    = swap_bytes(rx_aligned);

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        sclk    = bit_phase && !stall && (div_cnt >= HALFV);
        mosi    = ((state == ST_OPC) || (state == ST_ADR) || (state == ST_DATA)) ? sh[31] : 1'b0;
        cs_n    = '1;
        if (in_slot) cs_n[cmd_q.cs] = 1'b0;
        tx_pop  = word_start && cmd_q.dir_out && !tx_empty;
        rx_push = (state == ST_DATA) && !cmd_q.dir_out && bit_end &&
                  ((wbits == 5'd31) || (bits_left == BLW'(1)));
    end
endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
    import flash_seq_pkg::*;
#(
    parameter int SCLK_DIV   = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(FIFO_DEPTH);

    logic          srst_q, busy, tx_pop, rx_push;
    logic [4:0]    abits_q;
    logic [31:0]   tx_q, rx_d, rx_q;
    logic [LW-1:0] tx_cnt, rx_cnt, tx_free;
    logic          wr_cmd, wr_addr, wr_srst;

    assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD) && !srst_q;
    assign wr_addr = reg_wr && (reg_sel == SEL_ADDR) && !srst_q;
    assign wr_srst = reg_wr && (reg_sel == SEL_SRST) && reg_wdata[0];
    assign tx_free = FULL - tx_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            abits_q <= '0;
        end else begin
            srst_q <= wr_srst && !srst_q;
            if (reg_wr && reg_sel == SEL_ABITS) abits_q <= reg_wdata[4:0];
        end
    end

    flash_seq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(srst_q),
        .push(reg_wr && reg_sel == SEL_DATA && !srst_q), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_q), .level(tx_cnt)
    );

    flash_seq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(srst_q),
        .push(rx_push), .wdata(rx_d),
        .pop(reg_rd && reg_sel == SEL_DATA && !srst_q), .rdata(rx_q), .level(rx_cnt)
    );

    flash_seq_core #(.SCLK_DIV(SCLK_DIV), .NUM_CS(NUM_CS)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(srst_q),
        .cmd_we(wr_cmd), .addr_we(wr_addr), .wdata(reg_wdata), .abits(abits_q),
        .tx_empty(tx_cnt == '0), .tx_word(tx_q), .tx_pop(tx_pop),
        .rx_full(rx_cnt == FULL), .rx_push(rx_push), .rx_word(rx_d),
        .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_ABITS: reg_rdata = {27'd0, abits_q};
            SEL_DATA:  reg_rdata = rx_q;
            SEL_STAT:  reg_rdata = {31'd0, busy};
            SEL_FIFO:  reg_rdata = {11'd0, 5'(rx_cnt), 3'd0, 5'(tx_free), 4'd0,
                                    (rx_cnt == FULL), (rx_cnt == '0),
                                    (tx_cnt == '0), (tx_cnt == FULL)};
            SEL_SRST:  reg_rdata = {31'd0, srst_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/flash_cmd_engine_chk.sv
`timescale 1ns/1ps
module flash_cmd_engine_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 4,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst_q,
    input logic              busy,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              tx_pop,
    input logic              rx_push,
    input logic [LW-1:0]     tx_cnt,
    input logic [LW-1:0]     rx_cnt
);
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n)); // R12
    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk); // R12
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&spi_cs_n)); // R7
    AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_cnt < LW'(FIFO_DEPTH))); // R13
    AST_NO_TX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_cnt != '0)); // R13
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q); // R9
    AST_SRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (tx_cnt == '0 && rx_cnt == '0 && !busy && (&spi_cs_n))); // R9
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .srst_q(srst_q), .busy(busy),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .tx_pop(tx_pop), .rx_push(rx_push),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_cmd_engine #(.SCLK_DIV(DIV), .FIFO_DEPTH(16), .NUM_CS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    logic mbits [0:4095];
    int   mcnt = 0, ncnt = 0, cs_falls = 0;
    logic [3:0] cs_seen = '1;
    realtime t_fall = 0, t_rise = 0;
    wire cs_act = ~&spi_cs_n;

    function automatic logic [7:0] vbyte(input int b);
        return 8'(b * 29 + 60);
    endfunction
    function automatic logic fbit(input int i);
        logic [7:0] v;
        v = vbyte(i / 8);
        return v[7 - (i % 8)];
    endfunction
    function automatic logic [31:0] exp_word(input int b);
        return {vbyte(b + 3), vbyte(b + 2), vbyte(b + 1), vbyte(b)};
    endfunction

    assign spi_miso = fbit(ncnt);

    always @(posedge spi_sclk) begin mbits[mcnt] = spi_mosi; mcnt = mcnt + 1; end
    always @(negedge spi_sclk) begin ncnt = ncnt + 1; t_fall = $realtime; end
    always @(posedge cs_act) begin cs_falls = cs_falls + 1; cs_seen = spi_cs_n; end
    always @(negedge cs_act) t_rise = $realtime;

    function automatic logic [31:0] mval(input int start, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r = {r[30:0], mbits[start + k]};
        return r;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 20000; k++) begin
            rd(3'd4, s);
            if (s == 32'd0) return;
        end
    endtask

    task automatic model_clear();
        mcnt = 0; ncnt = 0;
    endtask

    function automatic logic [31:0] mkcmd(input int cs, input int nb, input int am,
                                          input int dout, input int dum, input logic [7:0] op);
        return {2'(cs), 14'(nb), 2'(am), 1'b0, 1'(dout), 4'(dum), op};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        rd(3'd4, v); chk("R7 idle status after reset", v, 32'd0);
        rd(3'd5, v); chk("R8 fifo status after reset", v, 32'h0000_1006);
        chk("R12 cs high after reset", {28'd0, spi_cs_n}, 32'hF);
        chk("R12 sclk low after reset", {31'd0, spi_sclk}, 32'd0);
    endtask

    task automatic t_opcode_only();
        int f0 = cs_falls;
        model_clear();
        wr(3'd0, mkcmd(2, 0, 0, 0, 0, 8'hA5));
        wait_idle();
        chk("R3 launch on command word", 32'(cs_falls - f0), 32'd1);
        chk("R1 opcode bit count", 32'(mcnt), 32'd8);
        chk("R1 opcode value", mval(0, 8), 32'hA5);
        chk("R1 selected chip select", {28'd0, cs_seen}, 32'hB);
        chk("R12 cs tail one sclk period", 32'(int'(t_rise - t_fall)), 32'(DIV * 8));
    endtask

    task automatic t_read();
        logic [31:0] v;
        int f0 = cs_falls;
        model_clear();
        wr(3'd0, mkcmd(0, 6, 1, 0, 8, 8'h0B));
        repeat (20) @(negedge clk);
        rd(3'd4, v); chk("R7 busy while armed", v, 32'd1);
        chk("R3 no cs before address", 32'(cs_falls - f0), 32'd0);
        wr(3'd1, 32'hFF12_3456);
        wait_idle();
        chk("R2 24-bit total bits", 32'(mcnt), 32'(40 + 48));
        chk("R1 read opcode", mval(0, 8), 32'h0B);
        chk("R2 24-bit address", mval(8, 24), 32'h12_3456);
        chk("R4 dummy clocks low", mval(32, 8), 32'd0);
        rd(3'd5, v); chk("R8 rx level two", v, 32'h0002_1002);
        rd(3'd3, v); chk("R6 rx full word", v, exp_word(5));
        rd(3'd3, v); chk("R6 rx partial word", v, {16'd0, vbyte(10), vbyte(9)});
    endtask

    task automatic t_write();
        logic [31:0] v;
        model_clear();
        wr(3'd3, 32'h4433_2211);
        wr(3'd3, 32'hAAAA_6655);
        rd(3'd5, v); chk("R8 tx free fourteen", v, 32'h0000_0E04);
        wr(3'd0, mkcmd(1, 6, 2, 1, 0, 8'h02));
        wr(3'd1, 32'hDEAD_BEEF);
        wait_idle();
        chk("R1 chip select one", {28'd0, cs_seen}, 32'hD);
        chk("R5 total bits", 32'(mcnt), 32'(8 + 32 + 48));
        chk("R2 32-bit address", mval(8, 32), 32'hDEAD_BEEF);
        chk("R5 bytes 0-3 lane order", mval(40, 32), 32'h1122_3344);
        chk("R5 partial word bytes", mval(72, 16), 32'h5566);
        rd(3'd5, v); chk("R8 tx empty after write", v, 32'h0000_1006);
    endtask

    task automatic t_custom_addr_only();
        logic [31:0] v;
        model_clear();
        wr(3'd2, 32'd11);
        rd(3'd2, v); chk("R2 width register readback", v, 32'd11);
        wr(3'd3, 32'h1357_9BDF);
        wr(3'd0, mkcmd(3, 0, 3, 0, 0, 8'h20));
        wr(3'd1, 32'hFFFF_FABC);
        wait_idle();
        chk("R2 custom width bit count", 32'(mcnt), 32'd20);
        chk("R2 custom address value", mval(8, 12), 32'hABC);
        rd(3'd5, v); chk("R10 no fifo traffic", v, 32'h0000_0F04);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr(3'd3, 32'h0102_0304);
        wr(3'd0, mkcmd(0, 16, 0, 1, 0, 8'h02));
        repeat (400) @(negedge clk);
        rd(3'd4, v); chk("R13 tx stall keeps busy", v, 32'd1);
        chk("R13 tx stall holds cs", {28'd0, spi_cs_n}, 32'hE);
        wr(3'd6, 32'd1);
        reg_sel = 3'd6; #1 v = reg_rdata;
        chk("R9 reset bit reads one", v, 32'd1);
        @(negedge clk); #1 v = reg_rdata;
        chk("R9 reset bit self clears", v, 32'd0);
        rd(3'd4, v); chk("R9 idle after reset", v, 32'd0);
        rd(3'd5, v); chk("R9 fifos emptied", v, 32'h0000_1006);
        chk("R9 cs released", {28'd0, spi_cs_n}, 32'hF);
    endtask

    task automatic t_tx_stall();
        logic [31:0] v;
        model_clear();
        wr(3'd3, 32'h8877_6655);
        wr(3'd0, mkcmd(0, 8, 0, 1, 0, 8'h32));
        repeat (300) @(negedge clk);
        chk("R13 stalled after first word", 32'(mcnt), 32'd40);
        rd(3'd4, v); chk("R13 busy during tx stall", v, 32'd1);
        wr(3'd3, 32'hCCBB_AA99);
        wait_idle();
        chk("R13 bits after resume", 32'(mcnt), 32'd72);
        chk("R5 second word order", mval(40, 32), 32'h99AA_BBCC);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int f0 = cs_falls;
        model_clear();
        wr(3'd0, mkcmd(3, 4, 0, 0, 0, 8'h9F));
        wr(3'd0, mkcmd(0, 0, 0, 0, 0, 8'h06));
        wr(3'd1, 32'h1111_1111);
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R11 single transaction", 32'(cs_falls - f0), 32'd1);
        chk("R11 opcode unchanged", mval(0, 8), 32'h9F);
        chk("R11 bit count unchanged", 32'(mcnt), 32'd40);
        rd(3'd3, v); chk("R6 id word", v, exp_word(1));
    endtask

    task automatic t_rx_stall();
        logic [31:0] v;
        model_clear();
        wr(3'd0, mkcmd(0, 68, 0, 0, 0, 8'h03));
        repeat (3000) @(negedge clk);
        rd(3'd4, v); chk("R13 busy while rx full", v, 32'd1);
        rd(3'd5, v); chk("R8 rx full flags", v, 32'h0010_100A);
        for (int j = 0; j < 16; j++) begin
            rd(3'd3, v); chk("R13 rx word no loss", v, exp_word(1 + 4 * j));
        end
        wait_idle();
        rd(3'd3, v); chk("R13 last rx word", v, exp_word(65));
        chk("R13 total clocks", 32'(mcnt), 32'(8 + 68 * 8));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_opcode_only();
        t_read();
        t_write();
        t_custom_addr_only();
        t_srst();
        t_tx_stall();
        t_busy_ignore();
        t_rx_stall();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule